// File: doc/BRIEF.md
# GPIO Port with Address-Masked Lower-Byte Writes

This block is a 16-pin general-purpose I/O port that sits on a simple 32-bit register bus. Software can read the synchronised pin levels and drive a 16-bit output register. A pending flag is latched for each pin, and each flag can be raised by a rising edge or by a high level. Software reads the pending flags and clears them by writing ones. An enable register gates the pending flags onto one combined interrupt line.

A 256-word window gives masked access to the lower eight output bits. In that window, the word address itself carries a per-bit enable mask. A write changes only the output bits whose mask bit is set, so software never needs a read-modify-write sequence to flip a subset of pins. The bus is single-cycle. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. Read data is combinational from the address and the current state.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the output register, the interrupt enable register, the interrupt type register and all pending flags are zero. As a result `pin_out` is 0 and `irq_out` is low.
- R2: A write to byte offset 0x004 loads all 16 output bits from `bus_wdata[15:0]`. Reading 0x004 returns them in [15:0] and zero in [31:16].
- R3: A read at offset 0x000 returns the pin inputs after a two-flop synchroniser. A pin change set up before clock edge k shows in the read data after edge k+1 and not after edge k.
- R4: A write at offset 0x400 + 4*m (m = 0..255) sets output bit i (i = 0..7) to `bus_wdata[i]` only when bit i of m (address bit i+2) is 1. Output bits whose mask bit is 0 keep their value.
- R5: A masked-window write never changes output bits [15:8], whatever the data in `bus_wdata[31:8]`.
- R6: A read at offset 0x400 + 4*m returns the output bits [7:0] ANDed with m in bits [7:0], and zero in bits [31:8].
- R7: When type bit i at offset 0x00C is 0, pin i is edge type. A 0-to-1 change of the synchronised pin sets pending flag i. The flag stays set after the pin falls, until software clears it.
- R8: When type bit i is 1, pin i is level type. Pending flag i is set in every cycle the synchronised pin is high, so a clear has no lasting effect while the pin stays high.
- R9: A read at offset 0x038 returns the 16 pending flags in [15:0] and zero in [31:16]. Writing 1 to bit i there clears flag i. Writing 0 leaves flag i unchanged.
- R10: If a new interrupt event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R11: `irq_out` is high exactly when some pending flag is set and its enable bit at offset 0x008 is 1.
- R12: Reads of unmapped offsets return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Output register value |
| irq_out | output | 1 | Combined enabled interrupt |

## Verification
The bench mixes random masked writes with sparse and dense address masks, including mask 0x00 and mask 0xFF. A design that took the mask from the data or from the wrong address bits would corrupt untouched output bits. A design that let window data reach bits [15:8] would show up in the full-register readback. A level-type pin is cleared while it is still high: a design that lets the clear beat the new event would show the flag dropping. The bench also samples the data register one edge early to catch a synchroniser with the wrong depth. Finally it writes to unmapped offsets to catch decode aliasing that would disturb the output register.

// File: rtl/gpio_mask_pkg.sv
// Package: shared widths, register offsets and decode enum of the GPIO
// masked-access port. Assumes a byte-addressed 12-bit register space.
package gpio_mask_pkg;
    localparam int unsigned GP_NPIN = 16;
    localparam int unsigned GP_AW   = 12;
    localparam int unsigned GP_DW   = 32;
    localparam int unsigned GP_MW   = 8;

    localparam logic [GP_AW-1:0] OFS_PINS  = 12'h000;
    localparam logic [GP_AW-1:0] OFS_DOUT  = 12'h004;
    localparam logic [GP_AW-1:0] OFS_IEN   = 12'h008;
    localparam logic [GP_AW-1:0] OFS_ITYPE = 12'h00C;
    localparam logic [GP_AW-1:0] OFS_ISTAT = 12'h038;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PINS,
        SEL_DOUT,
        SEL_IEN,
        SEL_ITYPE,
        SEL_ISTAT,
        SEL_MWIN
    } gp_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchroniser for the pin inputs plus one extra stage that
// holds the previous synchronised sample for edge detection.
// Assumes pins are asynchronous and only need metastability protection.
module gpio_in_sync #(
    parameter int unsigned NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] sync_o,
    output logic [NPIN-1:0] prev_o
);
    logic [NPIN-1:0] stage1_q;
    logic [NPIN-1:0] stage2_q;
    logic [NPIN-1:0] prev_q;

    // Purpose: shift pins through the synchroniser and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= pin_i;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign sync_o = stage2_q;
    assign prev_o = prev_q;

    // R3: the synchronised value is the pin value from two edges back.
    a_r3_two_flop: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> stage2_q == $past(pin_i, 2));
endmodule

// File: rtl/gpio_irq_latch.sv
// Module: per-pin pending-interrupt latches with edge or level detection,
// write-one-to-clear, and an enabled OR onto one interrupt line.
// Assumes sync/prev come from the same synchroniser. A new event beats a
// clear in the same cycle.
module gpio_irq_latch #(
    parameter int unsigned NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] sync_i,
    input  logic [NPIN-1:0] prev_i,
    input  logic [NPIN-1:0] itype_i,
    input  logic [NPIN-1:0] ien_i,
    input  logic [NPIN-1:0] clr_i,
    output logic [NPIN-1:0] pend_o,
    output logic            irq_o
);
    logic [NPIN-1:0] evt;
    logic [NPIN-1:0] pend_q;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        // Purpose: select the event source of pin p from its type bit.
        always_comb begin
            if (itype_i[p]) evt[p] = sync_i[p];
            else            evt[p] = sync_i[p] & ~prev_i[p];
        end

        // Purpose: latch pin p's pending flag; the event has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          pend_q[p] <= 1'b0;
            else if (evt[p])     pend_q[p] <= 1'b1;
            else if (clr_i[p])   pend_q[p] <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = |(pend_q & ien_i);

    // R10: every event seen in a cycle leaves its flag set, clear or not.
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_q & $past(evt)) == $past(evt));
    // R9: a clear with no event drops the flag.
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_q & $past(clr_i) & ~$past(evt)) == '0);
    // R9: without a clear a flag never drops.
    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($past(pend_q) & ~$past(clr_i) & ~pend_q) == '0);
endmodule

// File: rtl/gpio_bus_regs.sv
// Module: bus decode, the output/enable/type registers, the lower-byte
// masked window and the read mux. Assumes a single-cycle bus: writes
// commit on the edge with sel & wr, reads are combinational.
module gpio_bus_regs
    import gpio_mask_pkg::*;
#(
    parameter int unsigned NPIN = GP_NPIN,
    parameter int unsigned AW   = GP_AW,
    parameter int unsigned DW   = GP_DW,
    parameter int unsigned MW   = GP_MW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_i,
    input  logic            wr_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [NPIN-1:0] sync_i,
    input  logic [NPIN-1:0] pend_i,
    output logic [DW-1:0]   rdata_o,
    output logic [NPIN-1:0] dout_o,
    output logic [NPIN-1:0] ien_o,
    output logic [NPIN-1:0] itype_o,
    output logic [NPIN-1:0] clr_o
);
    localparam int unsigned WIN_LSB = MW + 2;
    localparam int unsigned WIN_TAG = 1;

    gp_sel_e         dec;
    logic [AW-1:0]   waddr;
    logic [MW-1:0]   mask;
    logic            we;
    logic            full_we;
    logic            mwin_we;
    logic [NPIN-1:0] dout_q;
    logic [NPIN-1:0] ien_q;
    logic [NPIN-1:0] itype_q;
    logic            unused_bits;

    assign waddr       = {addr_i[AW-1:2], 2'b00};
    assign mask        = addr_i[WIN_LSB-1:2];
    assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:NPIN]};

    // Purpose: map the word address onto one register select.
    always_comb begin
        if (addr_i[AW-1:WIN_LSB] == (AW-WIN_LSB)'(WIN_TAG))
            dec = SEL_MWIN;
        else begin
            case (waddr)
                OFS_PINS:  dec = SEL_PINS;
                OFS_DOUT:  dec = SEL_DOUT;
                OFS_IEN:   dec = SEL_IEN;
                OFS_ITYPE: dec = SEL_ITYPE;
                OFS_ISTAT: dec = SEL_ISTAT;
                default:   dec = SEL_NONE;
            endcase
        end
    end

    assign we      = sel_i & wr_i;
    assign full_we = we && (dec == SEL_DOUT);
    assign mwin_we = we && (dec == SEL_MWIN);
    assign clr_o   = (we && (dec == SEL_ISTAT)) ? wdata_i[NPIN-1:0] : '0;

    for (genvar b = 0; b < NPIN; b++) begin : g_dout
        if (b < MW) begin : g_masked
            // Purpose: output bit b, written by full or masked access.
            always_ff @(posedge clk) begin
                if (!rst_n)                    dout_q[b] <= 1'b0;
                else if (full_we)              dout_q[b] <= wdata_i[b];
                else if (mwin_we && mask[b])   dout_q[b] <= wdata_i[b];
            end
        end else begin : g_plain
            // Purpose: output bit b, written by full access only.
            always_ff @(posedge clk) begin
                if (!rst_n)        dout_q[b] <= 1'b0;
                else if (full_we)  dout_q[b] <= wdata_i[b];
            end
        end
    end

    // Purpose: interrupt enable and type registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q   <= '0;
            itype_q <= '0;
        end else if (we) begin
            if (dec == SEL_IEN)   ien_q   <= wdata_i[NPIN-1:0];
            if (dec == SEL_ITYPE) itype_q <= wdata_i[NPIN-1:0];
        end
    end

    // Purpose: read mux; unused bits and unmapped offsets read as zero.
    always_comb begin
        rdata_o = '0;
        case (dec)
            SEL_PINS:  rdata_o[NPIN-1:0] = sync_i;
            SEL_DOUT:  rdata_o[NPIN-1:0] = dout_q;
            SEL_IEN:   rdata_o[NPIN-1:0] = ien_q;
            SEL_ITYPE: rdata_o[NPIN-1:0] = itype_q;
            SEL_ISTAT: rdata_o[NPIN-1:0] = pend_i;
            SEL_MWIN:  rdata_o[MW-1:0]   = dout_q[MW-1:0] & mask;
            default:   rdata_o = '0;
        endcase
    end

    assign dout_o  = dout_q;
    assign ien_o   = ien_q;
    assign itype_o = itype_q;

    // R5: a window write leaves the upper output bits alone.
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(mwin_we) |-> dout_q[NPIN-1:MW] == $past(dout_q[NPIN-1:MW]));
    // R4: bits outside the address mask keep their value.
    a_r4_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(mwin_we) |->
            ((dout_q[MW-1:0] ^ $past(dout_q[MW-1:0])) & ~$past(mask)) == '0);
    // R12: a write to an unmapped offset changes no register.
    a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(we) && $past(dec) == SEL_NONE |->
            $stable(dout_q) && $stable(ien_q) && $stable(itype_q));
endmodule

// File: rtl/gpio_mask_port.sv
// Module: top of the 16-pin GPIO port with a lower-byte masked window.
// Wires the synchroniser, the register/decode block and the interrupt latches.
// Assumes synchronous active-low reset and a single-cycle register bus.
module gpio_mask_port
    import gpio_mask_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [GP_AW-1:0]    bus_addr,
    input  logic [GP_DW-1:0]    bus_wdata,
    output logic [GP_DW-1:0]    bus_rdata,
    input  logic [GP_NPIN-1:0]  pin_in,
    output logic [GP_NPIN-1:0]  pin_out,
    output logic                irq_out
);
    logic [GP_NPIN-1:0] sync_w;
    logic [GP_NPIN-1:0] prev_w;
    logic [GP_NPIN-1:0] pend_w;
    logic [GP_NPIN-1:0] ien_w;
    logic [GP_NPIN-1:0] itype_w;
    logic [GP_NPIN-1:0] clr_w;

    gpio_in_sync #(.NPIN(GP_NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    gpio_bus_regs #(
        .NPIN (GP_NPIN),
        .AW   (GP_AW),
        .DW   (GP_DW),
        .MW   (GP_MW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (bus_sel),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .sync_i  (sync_w),
        .pend_i  (pend_w),
        .rdata_o (bus_rdata),
        .dout_o  (pin_out),
        .ien_o   (ien_w),
        .itype_o (itype_w),
        .clr_o   (clr_w)
    );

    gpio_irq_latch #(.NPIN(GP_NPIN)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_w),
        .prev_i  (prev_w),
        .itype_i (itype_w),
        .ien_i   (ien_w),
        .clr_i   (clr_w),
        .pend_o  (pend_w),
        .irq_o   (irq_out)
    );

    // R11: with no enable bit set the line stays low.
    a_r11_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ien_w == '0 |-> !irq_out);
    // R11: the line is high only with some flag pending.
    a_r11_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> pend_w != '0);
    // R1: one cycle out of reset everything is cleared.
    a_r1_reset_state: assert property (@(posedge clk)
        $past(!rst_n) |-> pin_out == '0 && pend_w == '0 && !irq_out);
endmodule

// File: tb/gpio_mask_port_tb.sv
// Bench: directed corner cases plus seeded random traffic against a bench model.
module gpio_mask_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic        irq_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_out = '0, m_en = '0, m_typ = '0, m_pend = '0, m_pins = '0;

    gpio_mask_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] masked_update(logic [15:0] cur, logic [7:0] m, logic [31:0] d);
        return {cur[15:8], (cur[7:0] & ~m) | (d[7:0] & m)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_pins(logic [15:0] v);
        @(negedge clk);
        m_pend |= (~m_typ & v & ~m_pins) | (m_typ & v);
        pin_in = v;
        m_pins = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic clear_irq(logic [15:0] w);
        bwrite(12'h038, {16'hFFFF, w});
        m_pend = (m_pend & ~w) | (m_typ & m_pins);
    endtask

    task automatic set_type(logic [15:0] t);
        bwrite(12'h00C, {16'h0, t});
        m_typ = t;
        m_pend |= m_typ & m_pins;
        repeat (2) @(posedge clk);
    endtask

    task automatic check_irq(string req);
        logic [31:0] r;
        bread(12'h038, r);
        chk(req, r, {16'h0, m_pend});
        @(negedge clk);
        chk("R11 irq_out", {31'h0, irq_out}, {31'h0, |(m_pend & m_en)});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  mk;
        logic [31:0] d;
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
        chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
        bread(12'h038, r); chk("R1 pending", r, 32'h0);
        bread(12'h008, r); chk("R1 enable", r, 32'h0);
        bread(12'h00C, r); chk("R1 type", r, 32'h0);

        // R2 full write, upper data ignored
        bwrite(12'h004, 32'hDEAD_A5C3); m_out = 16'hA5C3;
        bread(12'h004, r); chk("R2 dout readback", r, 32'h0000_A5C3);
        chk("R2 pin_out", {16'h0, pin_out}, {16'h0, m_out});

        // R4/R5 mask 0x00 and 0xFF
        bwrite(12'h400, 32'hFFFF_FFFF);
        bread(12'h004, r); chk("R4 mask zero no effect", r, {16'h0, m_out});
        bwrite(12'h7FC, 32'hFFFF_0000); m_out = masked_update(m_out, 8'hFF, 32'h0);
        bread(12'h004, r); chk("R5 full mask, upper kept", r, {16'h0, m_out});

        // R6 masked read
        bwrite(12'h004, 32'h0000_12F0); m_out = 16'h12F0;
        bread(12'h400 | (8'h3C << 2), r); chk("R6 masked read", r, 32'h0000_0030);

        // R3 synchroniser depth
        @(negedge clk) pin_in = 16'h8001; m_pins = 16'h8001;
        @(posedge clk); #1 bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h000;
        @(negedge clk); chk("R3 one edge too early", bus_rdata, 32'h0);
        @(posedge clk); @(negedge clk); chk("R3 after two edges", bus_rdata, 32'h8001);
        bus_sel = 1'b0;
        m_pend |= 16'h8001; // edge-type rising events
        repeat (3) @(posedge clk);

        // R7 edge latch holds after fall
        check_irq("R7 edge pending");
        set_pins(16'h0000);
        check_irq("R7 held after fall");
        clear_irq(16'h0001);
        check_irq("R9 partial clear");
        clear_irq(16'h0000);
        check_irq("R9 zero write no effect");

        // R8/R10 level type clear while high
        set_type(16'h0010);
        set_pins(16'h0010);
        clear_irq(16'hFFFF);
        check_irq("R10 level re-asserts over clear");
        bwrite(12'h008, 32'h0000_0010); m_en = 16'h0010;
        check_irq("R8 level irq enabled");
        set_pins(16'h0000);
        clear_irq(16'h0010);
        check_irq("R8 clear after level drops");

        // R12 unmapped offsets
        bwrite(12'h010, 32'hFFFF_FFFF);
        bwrite(12'h3FC, 32'hFFFF_FFFF);
        bread(12'h010, r); chk("R12 unmapped read", r, 32'h0);
        bread(12'h004, r); chk("R12 dout untouched", r, {16'h0, m_out});
        bread(12'h00C, r); chk("R12 type untouched", r, {16'h0, m_typ});

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 6));
            case (op)
                0: begin
                    mk = 8'($urandom); d = $urandom;
                    bwrite(12'h400 | {2'b0, mk, 2'b00}, d);
                    m_out = masked_update(m_out, mk, d);
                    bread(12'h004, r); chk("R4 random masked write", r, {16'h0, m_out});
                end
                1: begin
                    mk = 8'($urandom);
                    bread(12'h400 | {2'b0, mk, 2'b00}, r);
                    chk("R6 random masked read", r, {24'h0, m_out[7:0] & mk});
                end
                2: begin
                    d = $urandom; bwrite(12'h004, d); m_out = d[15:0];
                    chk("R2 random full write", {16'h0, pin_out}, {16'h0, m_out});
                end
                3: begin
                    set_pins(16'($urandom));
                    bread(12'h000, r); chk("R3 random pins", r, {16'h0, m_pins});
                    check_irq("R7 random pending");
                end
                4: begin
                    clear_irq(16'($urandom));
                    check_irq("R9 random clear");
                end
                5: begin
                    d = $urandom; bwrite(12'h008, d); m_en = d[15:0];
                    check_irq("R11 random enable");
                end
                default: begin
                    set_type(16'($urandom));
                    check_irq("R8 random type");
                end
            endcase
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule